// File: doc/BRIEF.md
# Single-Phase Fan Commutation Controller

This block is the digital control core of a single-phase brushless fan driver. A Hall polarity bit from an external comparator and a PWM speed level enter it. It produces two bridge-side drive enables, a tach request that asks an open-drain pin to pull low, a Hall bias enable and a mode code. The analog amplifier, the output stage and the temperature sensor sit outside the block. Over-temperature arrives here as a plain digital flag.

The block runs in five modes. It enters a start-assist mode after reset, after leaving standby and after leaving lock protection. In that mode it drives at full strength and ignores PWM for a fixed number of cycles. The normal run mode gates the drive with PWM. When PWM is low the bridge falls into regeneration, with both sides low. If PWM stays low long enough, the block enters standby, and it leaves standby on the first high PWM sample. If the Hall polarity stops changing, the block enters lock protection. There it alternates short drive windows with off windows ten times as long. It stays in that loop until a polarity change arrives during a drive window. All times are clock-cycle counts set by parameters.

Top module: `fan_commut_ctrl`

## Requirements
- R1: In run mode with PWM high, a positive synchronized polarity gives drv_a_o=1, drv_b_o=0, and a negative polarity gives drv_a_o=0, drv_b_o=1. The two enables are never high together.
- R2: In run mode with PWM low, both drive enables are 0 whatever the polarity.
- R3: tach_low_o equals the Hall input delayed by two clock edges in every mode except standby. In standby it is 0 (released).
- R4: Standby is entered from run mode on the clock edge that samples the STBY_CYC-th consecutive low PWM level. Standby shows mode_o=2, bias_en_o=0 and both drives at 0.
- R5: In standby, the first clock edge that samples PWM high moves the block to start-assist (mode_o=0).
- R6: In run mode (mode_o=1), LOCK_DET_CYC consecutive edges without a synchronized polarity change move the block to the lock drive window (mode_o=3).
- R7: The lock drive window lasts LOCK_ON_CYC cycles and drives as in run mode. It is followed by an off window (mode_o=4) of LOCK_ON_CYC*LOCK_RATIO cycles (ratio 10 by default) with both drives at 0. The two windows then repeat.
- R8: A synchronized polarity change during the lock drive window moves the block to start-assist on the next edge. A Hall toggle is seen there on the third edge after it. Polarity changes during the off window have no effect.
- R9: Start-assist (mode_o=0) drives full strength by polarity whatever the PWM level, for ASSIST_CYC edges, and then enters run mode.
- R10: thermal_i high forces both drives to 0 without changing the mode. Drive resumes as soon as the flag clears.
- R11: During reset, mode_o=0, the synchronized polarity is negative and tach_low_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hall_i | input | 1 | Hall polarity, 1 = positive, asynchronous |
| pwm_i | input | 1 | PWM speed level |
| thermal_i | input | 1 | Over-temperature flag |
| drv_a_o | output | 1 | Bridge side A high-drive enable |
| drv_b_o | output | 1 | Bridge side B high-drive enable |
| tach_low_o | output | 1 | 1 = pull tach pin low |
| bias_en_o | output | 1 | Hall bias enable |
| mode_o | output | 3 | 0 assist, 1 run, 2 standby, 3 lock on, 4 lock off |

## Verification
The embedded properties check, on every cycle, the things that hold at every instant. The two drive enables are never high together. The thermal flag silences the drive. Standby has bias and drive off. Start-assist drives by polarity whatever the PWM level. The wake and lock-release transitions happen one edge after their cause, and the off window never ends early. The exact durations are left to the bench scenarios, which a property with a small window cannot span: the standby timeout count, the assist length, the lock-detect delay and the 1:10 on/off windows. The bench also shows that tach toggles during the off window are ignored while a toggle in the drive window releases lock. Its behavioural model is compared against every output on every cycle.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [2:0] {
    M_ASSIST   = 3'd0,
    M_RUN      = 3'd1,
    M_STBY     = 3'd2,
    M_LOCK_ON  = 3'd3,
    M_LOCK_OFF = 3'd4
  } fcc_mode_e;
endpackage

// File: rtl/fcc_hall_sync.sv
module fcc_hall_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hall_i,
  output logic pol_o,
  output logic edge_o
);
  logic [STAGES:0] sr_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[0] <= 1'b0;
          else         sr_q[0] <= hall_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[g] <= 1'b0;
          else         sr_q[g] <= sr_q[g-1];
      end
    end
  endgenerate

  assign pol_o  = sr_q[STAGES-1];
  assign edge_o = sr_q[STAGES-1] ^ sr_q[STAGES];
endmodule

// File: rtl/fcc_stby_det.sv
module fcc_stby_det #(
  parameter int unsigned STBY_CYC = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic hit_o
);
  localparam int unsigned SW = $clog2(STBY_CYC + 1);
  localparam logic [SW-1:0] LAST = SW'(STBY_CYC - 1);

  logic [SW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             low_cnt_q <= '0;
    else if (pwm_i)          low_cnt_q <= '0;
    else if (low_cnt_q != LAST) low_cnt_q <= low_cnt_q + 1'b1;

  // hit on the STBY_CYC-th consecutive low sample
  assign hit_o = !pwm_i && (low_cnt_q == LAST);
endmodule

// File: rtl/fcc_mode_seq.sv
module fcc_mode_seq
  import fcc_pkg::*;
#(
  parameter int unsigned ASSIST_CYC   = 25000000,
  parameter int unsigned LOCK_DET_CYC = 150000000,
  parameter int unsigned LOCK_ON_CYC  = 150000000,
  parameter int unsigned LOCK_RATIO   = 10
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pwm_i,
  input  logic      hall_edge_i,
  input  logic      stby_hit_i,
  output fcc_mode_e mode_o
);
  localparam int unsigned LOCK_OFF_CYC = LOCK_ON_CYC * LOCK_RATIO;
  localparam int unsigned TW = $clog2(LOCK_OFF_CYC + ASSIST_CYC + 1);
  localparam int unsigned LW = $clog2(LOCK_DET_CYC + 1);
  localparam logic [TW-1:0] ASSIST_LAST = TW'(ASSIST_CYC - 1);
  localparam logic [TW-1:0] ON_LAST     = TW'(LOCK_ON_CYC - 1);
  localparam logic [TW-1:0] OFF_LAST    = TW'(LOCK_OFF_CYC - 1);
  localparam logic [LW-1:0] DET_LAST    = LW'(LOCK_DET_CYC - 1);

  fcc_mode_e     st_q, st_d;
  logic [TW-1:0] tmr_q;
  logic [LW-1:0] idle_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      M_ASSIST:   if (tmr_q == ASSIST_LAST) st_d = M_RUN;
      M_RUN: begin
        if (stby_hit_i)                              st_d = M_STBY;
        else if (!hall_edge_i && idle_q == DET_LAST) st_d = M_LOCK_ON;
      end
      M_STBY:     if (pwm_i) st_d = M_ASSIST;
      M_LOCK_ON: begin
        if (hall_edge_i)          st_d = M_ASSIST;
        else if (tmr_q == ON_LAST) st_d = M_LOCK_OFF;
      end
      M_LOCK_OFF: if (tmr_q == OFF_LAST) st_d = M_LOCK_ON;
      default:    st_d = M_ASSIST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q   <= M_ASSIST;
      tmr_q  <= '0;
      idle_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= (st_d != st_q) ? '0 : tmr_q + 1'b1;
      if (st_d != M_RUN || st_q != M_RUN || hall_edge_i) idle_q <= '0;
      else                                              idle_q <= idle_q + 1'b1;
    end

  assign mode_o = st_q;

  // R5
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == M_STBY && pwm_i) |=> st_q == M_ASSIST);

  // R8
  lock_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == M_LOCK_ON && hall_edge_i) |=> st_q == M_ASSIST);

  // R8
  off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == M_LOCK_OFF && tmr_q != OFF_LAST) |=> st_q == M_LOCK_OFF);
endmodule

// File: rtl/fcc_out_dec.sv
module fcc_out_dec
  import fcc_pkg::*;
(
  input  fcc_mode_e mode_i,
  input  logic      pol_i,
  input  logic      pwm_i,
  input  logic      thermal_i,
  output logic      drv_a_o,
  output logic      drv_b_o,
  output logic      tach_low_o,
  output logic      bias_en_o
);
  logic drive_ok, gate;

  always_comb begin
    drive_ok = !thermal_i &&
               (mode_i == M_ASSIST || mode_i == M_RUN || mode_i == M_LOCK_ON);
    // assist ignores PWM; elsewhere PWM low means regeneration
    gate       = (mode_i == M_ASSIST) ? 1'b1 : pwm_i;
    drv_a_o    = drive_ok && gate && pol_i;
    drv_b_o    = drive_ok && gate && !pol_i;
    tach_low_o = pol_i && (mode_i != M_STBY);
    bias_en_o  = (mode_i != M_STBY);
  end
endmodule

// File: rtl/fan_commut_ctrl.sv
module fan_commut_ctrl
  import fcc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned STBY_CYC     = 200000,
  parameter int unsigned ASSIST_CYC   = 25000000,
  parameter int unsigned LOCK_DET_CYC = 150000000,
  parameter int unsigned LOCK_ON_CYC  = 150000000,
  parameter int unsigned LOCK_RATIO   = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hall_i,
  input  logic       pwm_i,
  input  logic       thermal_i,
  output logic       drv_a_o,
  output logic       drv_b_o,
  output logic       tach_low_o,
  output logic       bias_en_o,
  output logic [2:0] mode_o
);
  logic      pol, hall_edge, stby_hit;
  fcc_mode_e mode;

  fcc_hall_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .hall_i(hall_i),
    .pol_o(pol), .edge_o(hall_edge)
  );

  fcc_stby_det #(.STBY_CYC(STBY_CYC)) u_stby (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(pwm_i), .hit_o(stby_hit)
  );

  fcc_mode_seq #(
    .ASSIST_CYC(ASSIST_CYC), .LOCK_DET_CYC(LOCK_DET_CYC),
    .LOCK_ON_CYC(LOCK_ON_CYC), .LOCK_RATIO(LOCK_RATIO)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(pwm_i),
    .hall_edge_i(hall_edge), .stby_hit_i(stby_hit), .mode_o(mode)
  );

  fcc_out_dec u_dec (
    .mode_i(mode), .pol_i(pol), .pwm_i(pwm_i), .thermal_i(thermal_i),
    .drv_a_o(drv_a_o), .drv_b_o(drv_b_o),
    .tach_low_o(tach_low_o), .bias_en_o(bias_en_o)
  );

  assign mode_o = mode;

  // R1
  no_shoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_a_o && drv_b_o));

  // R10
  thermal_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thermal_i |-> (!drv_a_o && !drv_b_o));

  // R4
  stby_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_STBY) |-> (!bias_en_o && !drv_a_o && !drv_b_o));

  // R9
  assist_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_ASSIST && !thermal_i) |-> (drv_a_o || drv_b_o));
endmodule

// File: tb/fan_commut_ctrl_bench.sv
`timescale 1ns/1ps
module fan_commut_ctrl_bench;
  localparam int STBY = 20, ASSIST = 12, DET = 60, ON = 15, RATIO = 10;
  localparam int OFF = ON * RATIO;

  logic clk = 1'b0, rst_n = 1'b0, hall = 1'b0, pwm = 1'b0, therm = 1'b0;
  logic drv_a, drv_b, tach, bias;
  logic [2:0] mode;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fan_commut_ctrl #(
    .STBY_CYC(STBY), .ASSIST_CYC(ASSIST), .LOCK_DET_CYC(DET),
    .LOCK_ON_CYC(ON), .LOCK_RATIO(RATIO)
  ) u_fan_commut_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hall_i(hall), .pwm_i(pwm), .thermal_i(therm),
    .drv_a_o(drv_a), .drv_b_o(drv_b), .tach_low_o(tach), .bias_en_o(bias),
    .mode_o(mode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit h_d[$] = '{0, 0, 0};   // hall history, newest at front
  int m_state = 0, m_tmr = 0, m_idle = 0, m_low = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_d = '{0, 0, 0}; m_state = 0; m_tmr = 0; m_idle = 0; m_low = 0;
    end else begin
      automatic bit chg = (h_d[1] != h_d[2]);
      automatic int nxt = m_state;
      m_low = pwm ? 0 : m_low + 1;
      case (m_state)
        0: if (m_tmr + 1 == ASSIST) nxt = 1;
        1: if (m_low >= STBY) nxt = 2;
           else if (!chg && m_idle + 1 == DET) nxt = 3;
        2: if (pwm) nxt = 0;
        3: if (chg) nxt = 0; else if (m_tmr + 1 == ON) nxt = 4;
        4: if (m_tmr + 1 == OFF) nxt = 3;
        default: nxt = 0;
      endcase
      m_idle = (nxt == 1 && m_state == 1 && !chg) ? m_idle + 1 : 0;
      m_tmr  = (nxt != m_state) ? 0 : m_tmr + 1;
      m_state = nxt;
      h_d.push_front(hall);
      void'(h_d.pop_back());
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      automatic bit pol = h_d[1];
      automatic bit ok = !therm && (m_state == 0 || m_state == 1 || m_state == 3);
      automatic bit g = (m_state == 0) ? 1'b1 : pwm;
      automatic bit ea = ok && g && pol, eb = ok && g && !pol;
      automatic string dtag = therm ? "R10" : (m_state == 0) ? "R9" :
                              (m_state == 4) ? "R7" : (m_state == 2) ? "R4" :
                              (m_state == 3) ? "R7" : pwm ? "R1" : "R2";
      automatic string mtag = (m_state == 2) ? "R4" : (m_state >= 3) ? "R7" :
                              (m_state == 0) ? "R9" : "R6";
      chk(mode == m_state[2:0], mtag, mode, m_state);
      chk(drv_a == ea, {dtag, " drv_a"}, drv_a, ea);
      chk(drv_b == eb, {dtag, " drv_b"}, drv_b, eb);
      chk(tach == (pol && m_state != 2), "R3", tach, pol && m_state != 2);
      chk(bias == (m_state != 2), "R4 bias", bias, m_state != 2);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic spin(input int n, input bit toggle);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (toggle && (i % 8 == 0)) hall = ~hall;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #1;
    chk(mode == 0, "R11 mode", mode, 0);
    chk(tach == 0, "R11 tach", tach, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: assist ignores low PWM, lasts ASSIST edges
    n = 0;
    do begin @(posedge clk); #1; n++; if (mode == 0) chk(drv_b == 1, "R9 full", drv_b, 1); end
    while (mode != 1 && n < 100);
    chk(n == ASSIST, "R9 length", n, ASSIST);
    // R1/R2 with PWM patterns
    for (int p = 0; p < 6; p++) begin
      @(negedge clk); pwm = p[0]; hall = p[1];
      spin(3, 0);
      #1;
      if (pwm) chk(drv_a == hall && drv_b == !hall, "R1", {drv_a, drv_b}, {hall, !hall});
      else     chk(!drv_a && !drv_b, "R2", {drv_a, drv_b}, 0);
    end
    @(negedge clk); pwm = 1;
    spin(20, 1);
    // R10
    @(negedge clk); therm = 1;
    spin(5, 1);
    #1;
    chk(!drv_a && !drv_b && mode == 1, "R10 off", {drv_a, drv_b, mode}, 1);
    @(negedge clk); therm = 0;
    #1;
    chk(drv_a || drv_b, "R10 resume", {drv_a, drv_b}, 1);
    // R4 standby timeout
    @(negedge clk); pwm = 0;
    n = 0;
    do begin
      @(posedge clk); #1; n++;
      if (n % 8 == 0) begin @(negedge clk); hall = ~hall; end
    end while (mode != 2 && n < 200);
    chk(n == STBY, "R4 timeout", n, STBY);
    spin(6, 1);
    #1;
    chk(bias == 0 && tach == 0, "R4 R3 quiet", {bias, tach}, 0);
    // R5 wake
    @(negedge clk); pwm = 1;
    @(posedge clk); #1;
    chk(mode == 0, "R5 wake", mode, 0);
    spin(ASSIST + 4, 1);
    // R6/R7 lock
    n = 0;
    while (mode != 3 && n < 300) begin @(posedge clk); #1; n++; end
    chk(mode == 3, "R6 lock", mode, 3);
    n = 0;
    while (mode == 3) begin @(posedge clk); #1; n++; end
    chk(n == ON, "R7 on", n, ON);
    n = 0;
    while (mode == 4 && n < 1000) begin
      @(posedge clk); #1; n++;
      if (n == 20 || n == 40) begin @(negedge clk); hall = ~hall; end
    end
    chk(n == OFF, "R8 R7 off ignores", n, OFF);
    chk(mode == 3, "R7 repeat", mode, 3);
    // R8 release
    @(negedge clk); hall = ~hall;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (mode != 0 && n < 20);
    chk(n == 3, "R8 release", n, 3);
    spin(ASSIST + 10, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule